// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static RAM meant to hold cache data behind a processor. Every input except the output enable is sampled on the rising clock edge. A cycle either starts a burst at the external address or continues the burst in progress at an address that a 2-bit counter produces on the two low address bits. The counter runs in linear or interleaved order. Writes take effect from the clock edge, so no write strobe has to be shaped outside the block. Each of the two 9-bit byte lanes has its own write enable, and a global write enable writes both lanes.

Read data passes through one output register, so a read address sampled at one edge is on the output after the following edge. The pins are modelled as a data-out bus and a valid flag, and the output enable gates both combinationally. The depth comes from `ADDR_W`. A 65536-word part uses `ADDR_W = 16`; the default is kept smaller so that a default elaboration stays light.

Top module: `bsram_pipe`

## Requirements
- R1: A read whose address is sampled at edge E drives that word on `rdata_o`, with `rvalid_o` high, after edge E+1. A write followed in the next cycle by a read of the same address returns the new data.
- R2: A cycle with `cpu_stb_n_i` low and `cs1_n_i` low starts a burst at `addr_i`. A cycle with `ctl_stb_n_i` low and no such processor start also starts a burst at `addr_i`. While `cs1_n_i` is high, `cpu_stb_n_i` is ignored.
- R3: With the order latched low at the start, the k-th advance after the start accesses low address bits (start + k) mod 4. The upper address bits stay fixed.
- R4: With the order latched high at the start, the k-th advance accesses low address bits equal to the start value XOR k.
- R5: Continue cycles are cycles with no strobe while a burst is active. On a continue cycle the counter steps only when `adv_n_i` is low. Otherwise the same address is accessed again.
- R6: When `we_n_i` is low, lane a (bits 8:0) is written if `lane_en_n_i[0]` is low, and lane b (bits 17:9) is written if `lane_en_n_i[1]` is low. A lane whose enable is high keeps its old contents.
- R7: When `gwe_n_i` is low, both lanes are written, whatever the values of `we_n_i` and `lane_en_n_i`.
- R8: A cycle started by the processor strobe is a read, even when write enables are asserted.
- R9: The chip is selected only when `cs1_n_i` is low, `cs2_i` is high and `cs3_n_i` is low. A start cycle without that selection performs no access and leaves `rvalid_o` low in its output slot. Later continue cycles do nothing until the next selected start.
- R10: While `oe_n_i` is high, `rvalid_o` and `rdata_o` are zero in the same cycle.
- R11: After reset, `rvalid_o` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low reset of the control state |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | 2*LANE_W | Write data, lane b above lane a |
| cs1_n_i | input | 1 | Chip select 1, active low |
| cs2_i | input | 1 | Chip select 2, active high |
| cs3_n_i | input | 1 | Chip select 3, active low |
| cpu_stb_n_i | input | 1 | Processor-side burst start, active low |
| ctl_stb_n_i | input | 1 | Controller-side burst start, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gwe_n_i | input | 1 | Global write enable, active low |
| we_n_i | input | 1 | Write enable for lane writes, active low |
| lane_en_n_i | input | 2 | Per-lane write enables, active low |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n_i | input | 1 | Output enable, active low, not registered |
| rdata_o | output | 2*LANE_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench builds the block with `ADDR_W = 6` and `LANE_W = 9`. A 64-word array is small enough to fill completely, so every burst read can be compared with a reference array. The table of bursts uses start addresses with each low-bit value and both orders. It includes suspended advances and the wrap back to the start word. Directed cycles cover byte-masked writes on each lane, a processor start with writes asserted, an ignored processor strobe, each deselect path and output-enable gating.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int LANES = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic             active;
        logic             rd;
        logic [LANES-1:0] wr;
    } op_t;

endpackage

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] cur_addr_o
);

    localparam int CNT_W = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        order_e            ord;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] low;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.base = ext_addr_i;
            st_d.cnt  = '0;
            st_d.ord  = order_e'(order_i);
        end else if (step_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (st_q.ord == ORD_INTERLEAVE) begin
            low = st_q.base[CNT_W-1:0] ^ st_d.cnt;
        end else begin
            low = st_q.base[CNT_W-1:0] + st_d.cnt;
        end

        if (load_i) begin
            cur_addr_o = ext_addr_i;
        end else begin
            cur_addr_o = {st_q.base[ADDR_W-1:CNT_W], low};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{base: '0, cnt: '0, ord: ORD_LINEAR};
        end else begin
            st_q <= st_d;
        end
    end

    AST_LOAD_CLEARS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (st_q.cnt == '0));                                          // R3
    AST_SUSPEND_HOLDS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !step_i) |=> $stable(st_q.cnt));                           // R5
    AST_BASE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(st_q.base));                                       // R2

endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic              clk_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANE_W-1:0] wdata_i,
    output logic [LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rdata_q;

    always_ff @(posedge clk_i) begin
        if (wr_i) begin
            mem_q[addr_i] <= wdata_i;
        end
        if (rd_i) begin
            rdata_q <= mem_q[addr_i];
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/bsram_pipe.sv
module bsram_pipe
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              cs1_n_i,
    input  logic              cs2_i,
    input  logic              cs3_n_i,
    input  logic              cpu_stb_n_i,
    input  logic              ctl_stb_n_i,
    input  logic              adv_n_i,
    input  logic              gwe_n_i,
    input  logic              we_n_i,
    input  logic [1:0]        lane_en_n_i,
    input  logic              order_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    typedef struct packed {
        op_t               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rvalid;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic              chip_en, cpu_start, ctl_start, start;
    logic              load, step;
    logic [LANES-1:0]  lane_wr;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] lane_rdata;

    always_comb begin
        chip_en   = !cs1_n_i && cs2_i && !cs3_n_i;
        cpu_start = !cpu_stb_n_i && !cs1_n_i;
        ctl_start = !ctl_stb_n_i && !cpu_start;
        start     = cpu_start || ctl_start;
        for (int l = 0; l < LANES; l++) begin
            lane_wr[l] = !gwe_n_i || (!we_n_i && !lane_en_n_i[l]);
        end
    end

    always_comb begin
        pipe_d        = pipe_q;
        load          = 1'b0;
        step          = 1'b0;
        pipe_d.rvalid = pipe_q.op.rd;
        pipe_d.addr   = cur_addr;
        pipe_d.wdata  = wdata_i;
        if (start) begin
            load             = 1'b1;
            pipe_d.op.active = chip_en;
            pipe_d.op.rd     = chip_en && (cpu_start || !(|lane_wr));
            pipe_d.op.wr     = (chip_en && ctl_start) ? lane_wr : '0;
        end else if (pipe_q.op.active) begin
            step         = !adv_n_i;
            pipe_d.op.rd = !(|lane_wr);
            pipe_d.op.wr = lane_wr;
        end else begin
            pipe_d.op.rd = 1'b0;
            pipe_d.op.wr = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    bsram_burst_addr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .step_i     (step),
        .order_i    (order_i),
        .ext_addr_i (addr_i),
        .cur_addr_o (cur_addr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bsram_lane #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
        ) u_lane (
            .clk_i   (clk_i),
            .wr_i    (pipe_q.op.wr[g]),
            .rd_i    (pipe_q.op.rd),
            .addr_i  (pipe_q.addr),
            .wdata_i (pipe_q.wdata[g*LANE_W +: LANE_W]),
            .rdata_o (lane_rdata[g*LANE_W +: LANE_W])
        );
    end

    assign rvalid_o = pipe_q.rvalid && !oe_n_i;
    assign rdata_o  = rvalid_o ? lane_rdata : '0;

    AST_CPU_START_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_start |=> (pipe_q.op.wr == '0));                                   // R8
    AST_DESELECT_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && !chip_en) |=> ##1 !pipe_q.rvalid);                           // R9
    AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start && chip_en && cpu_start) |=> ##1 pipe_q.rvalid);                // R1
    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pipe_q.op.rd && (|pipe_q.op.wr)));                                   // R6

endmodule

// File: tb/bsram_pipe_bench.sv
module bsram_pipe_bench;

    localparam int AW    = 6;
    localparam int LW    = 9;
    localparam int DW    = 2 * LW;
    localparam int DEPTH = 1 << AW;

    // Burst table: [11] order, [10] processor strobe, [9:6] advance per continue cycle, [5:0] start address
    localparam logic [11:0] BURST_TAB [8] = '{
        {1'b0, 1'b0, 4'b1111, 6'd0},
        {1'b0, 1'b0, 4'b1111, 6'd6},
        {1'b1, 1'b0, 4'b1111, 6'd9},
        {1'b1, 1'b1, 4'b1111, 6'd15},
        {1'b0, 1'b1, 4'b1011, 6'd22},
        {1'b1, 1'b0, 4'b0110, 6'd31},
        {1'b0, 1'b0, 4'b1111, 6'd47},
        {1'b1, 1'b1, 4'b1101, 6'd62}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          cs1_n, cs2, cs3_n, cpu_n, ctl_n, adv_n, gwe_n, we_n, ord, oe_n;
    logic [1:0]    len_n;
    logic [DW-1:0] rdata;
    logic          rvalid;

    // staged inputs for the next cycle
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wdata;
    logic          s_cs1_n, s_cs2, s_cs3_n, s_cpu_n, s_ctl_n, s_adv_n, s_gwe_n, s_we_n, s_ord, s_oe_n;
    logic [1:0]    s_len_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [DEPTH];
    logic          m_act = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_ord = 1'b0;

    logic          p1_v = 1'b0, p2_v = 1'b0;
    logic [DW-1:0] p1_d = '0, p2_d = '0;
    string         p1_t = "", p2_t = "";

    always #2 clk = ~clk;

    bsram_pipe #(
        .ADDR_W (AW),
        .LANE_W (LW)
    ) u_bsram_pipe (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .cs1_n_i     (cs1_n),
        .cs2_i       (cs2),
        .cs3_n_i     (cs3_n),
        .cpu_stb_n_i (cpu_n),
        .ctl_stb_n_i (ctl_n),
        .adv_n_i     (adv_n),
        .gwe_n_i     (gwe_n),
        .we_n_i      (we_n),
        .lane_en_n_i (len_n),
        .order_i     (ord),
        .oe_n_i      (oe_n),
        .rdata_o     (rdata),
        .rvalid_o    (rvalid)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        s_addr = '0; s_wdata = '0;
        s_cs1_n = 1'b0; s_cs2 = 1'b1; s_cs3_n = 1'b0;
        s_cpu_n = 1'b1; s_ctl_n = 1'b1; s_adv_n = 1'b1;
        s_gwe_n = 1'b1; s_we_n = 1'b1; s_len_n = 2'b11;
        s_ord = 1'b0; s_oe_n = 1'b0;
    endtask

    function automatic logic [AW-1:0] burst_addr();
        logic [1:0] low;
        low = m_ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], low};
    endfunction

    // one clock: apply staged inputs, check the slot issued two cycles ago, model this cycle
    task automatic cyc(input string tag);
        logic          sel, cpu_s, ctl_s, cur_v, ev;
        logic [1:0]    wr;
        logic [AW-1:0] a;
        logic [DW-1:0] cur_d;
        @(negedge clk);
        addr = s_addr; wdata = s_wdata; cs1_n = s_cs1_n; cs2 = s_cs2; cs3_n = s_cs3_n;
        cpu_n = s_cpu_n; ctl_n = s_ctl_n; adv_n = s_adv_n; gwe_n = s_gwe_n; we_n = s_we_n;
        len_n = s_len_n; ord = s_ord; oe_n = s_oe_n;
        #1;
        ev = p2_v && !oe_n;
        chk(rvalid === ev, {p2_t, " valid"}, 32'(rvalid), 32'(ev));
        chk(rdata === (ev ? p2_d : '0), {p2_t, " data"}, 32'(rdata), 32'(ev ? p2_d : '0));
        sel   = !cs1_n && cs2 && !cs3_n;
        cpu_s = !cpu_n && !cs1_n;
        ctl_s = !ctl_n && !cpu_s;
        for (int l = 0; l < 2; l++) wr[l] = !gwe_n || (!we_n && !len_n[l]);
        cur_v = 1'b0; cur_d = '0; a = '0;
        if (cpu_s || ctl_s) begin
            m_act = sel; m_base = addr; m_cnt = '0; m_ord = ord; a = addr;
            if (sel) begin
                if (ctl_s && (|wr)) begin
                    if (wr[0]) ref_mem[a][LW-1:0]  = wdata[LW-1:0];
                    if (wr[1]) ref_mem[a][DW-1:LW] = wdata[DW-1:LW];
                end else begin
                    cur_v = 1'b1; cur_d = ref_mem[a];
                end
            end
        end else if (m_act) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            a = burst_addr();
            if (|wr) begin
                if (wr[0]) ref_mem[a][LW-1:0]  = wdata[LW-1:0];
                if (wr[1]) ref_mem[a][DW-1:LW] = wdata[DW-1:LW];
            end else begin
                cur_v = 1'b1; cur_d = ref_mem[a];
            end
        end
        p2_v = p1_v; p2_d = p1_d; p2_t = p1_t;
        p1_v = cur_v; p1_d = cur_d; p1_t = tag;
        defaults();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        defaults();
        addr = '0; wdata = '0; cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1;
        cpu_n = 1'b1; ctl_n = 1'b1; adv_n = 1'b1; gwe_n = 1'b1; we_n = 1'b1;
        len_n = 2'b11; ord = 1'b0; oe_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(rvalid === 1'b0, "R11 valid in reset", 32'(rvalid), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: idle after reset yields nothing
        cyc("R11 idle"); cyc("R11 idle"); cyc("R11 idle");

        // R7: fill the array with global writes
        for (int i = 0; i < DEPTH; i++) begin
            s_ctl_n = 1'b0; s_gwe_n = 1'b0; s_we_n = 1'b1; s_len_n = 2'b11;
            s_addr = AW'(i); s_wdata = DW'(i * 1021 + 77);
            cyc("R7 fill");
        end
        s_ctl_n = 1'b0; s_addr = 6'd33; cyc("R7 readback"); cyc("R1 R5 suspend");

        // R1 R2 R3 R4 R5: table of bursts
        for (int b = 0; b < 8; b++) begin
            logic [11:0] e;
            e = BURST_TAB[b];
            if (e[10]) s_cpu_n = 1'b0; else s_ctl_n = 1'b0;
            s_addr = e[5:0]; s_ord = e[11];
            cyc(e[11] ? "R4 start" : "R3 start");
            for (int k = 0; k < 4; k++) begin
                s_adv_n = !e[6 + k];
                cyc(e[11] ? "R4 R5 continue" : "R3 R5 continue");
            end
        end

        // R6 R1: lane a only, then back-to-back read
        s_ctl_n = 1'b0; s_we_n = 1'b0; s_len_n = 2'b10; s_addr = 6'd5; s_wdata = 18'h2A5A5;
        cyc("R6 lane a write");
        s_ctl_n = 1'b0; s_addr = 6'd5; cyc("R6 R1 read after lane a");
        s_ctl_n = 1'b0; s_we_n = 1'b0; s_len_n = 2'b01; s_addr = 6'd5; s_wdata = 18'h15A5A;
        cyc("R6 lane b write");
        s_ctl_n = 1'b0; s_addr = 6'd5; cyc("R6 R1 read after lane b");
        s_ctl_n = 1'b0; s_we_n = 1'b1; s_len_n = 2'b00; s_addr = 6'd5; s_wdata = 18'h0;
        cyc("R6 no write without we");
        s_ctl_n = 1'b0; s_we_n = 1'b0; s_len_n = 2'b00; s_addr = 6'd8; s_wdata = 18'h3FFFF;
        cyc("R6 both lanes");
        s_ctl_n = 1'b0; s_addr = 6'd8; cyc("R6 read both lanes");

        // R8: processor start with writes asserted is a read
        s_cpu_n = 1'b0; s_gwe_n = 1'b0; s_we_n = 1'b0; s_len_n = 2'b00; s_addr = 6'd7; s_wdata = 18'h0;
        cyc("R8 cpu start read");
        s_ctl_n = 1'b0; s_addr = 6'd7; cyc("R8 word unchanged");

        // R2: processor strobe ignored while cs1 high
        s_ctl_n = 1'b0; s_addr = 6'd12; cyc("R2 ctl start");
        s_cpu_n = 1'b0; s_cs1_n = 1'b1; s_addr = 6'd40; cyc("R2 cpu ignored");
        cyc("R2 drain");

        // R9: deselect paths
        s_ctl_n = 1'b0; s_cs2 = 1'b0; s_addr = 6'd3; cyc("R9 cs2 low");
        s_adv_n = 1'b0; cyc("R9 no continue");
        s_cpu_n = 1'b0; s_cs3_n = 1'b1; s_addr = 6'd3; cyc("R9 cs3 high");
        s_ctl_n = 1'b0; s_cs1_n = 1'b1; s_addr = 6'd3; cyc("R9 cs1 high");
        cyc("R9 idle"); cyc("R9 idle");

        // R10: output enable gating
        s_ctl_n = 1'b0; s_addr = 6'd9; cyc("R10 read");
        s_cs2 = 1'b0; s_ctl_n = 1'b0; cyc("R10 deselect");
        s_oe_n = 1'b1; cyc("R10 gated");
        s_ctl_n = 1'b0; s_addr = 6'd10; cyc("R10 read ungated");
        cyc("R10 suspend"); cyc("R10 drain"); cyc("R10 drain");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule